// File: doc/BRIEF.md
# DMA Channel Interrupt and Status Registers

This block is the register bank that sits beside one DMA channel's datapath. It gathers eight interrupt sources into a sticky pending register and gates them with a mask. Software changes the mask only through two write ports: one that unmasks and one that masks. The block drives a single level-sensitive interrupt line. It also presents a status word that shows the channel's busy flag and a 3-bit counter of completed transfers. Acknowledging the done interrupt counts that counter down.

The datapath reports its events on single-cycle pulse lines, one line per source. The invalid-access source is raised inside the block whenever a word access hits an unmapped register slot. Two control words are held only as storage, with their reset values, for the datapath to use. Software reaches the registers over a simple 32-bit word bus. Writes are taken on the clock edge while `req_i` and `we_i` are high. Read data is combinational while `req_i` is high and `we_i` is low. Register slots, as byte offsets: 0x00 status word, 0x04 control, 0x08 control-2, 0x0C pending, 0x10 unmask, 0x14 mask-set, 0x18 mask (read only). Every other word-aligned offset is unmapped.

Top module: `dma_irq_regs`

## Requirements
- R1: Pending bit positions are: 0 memory done, 1 done, 2 bus error, 3 stream timeout, 4 memory timeout, 5 threshold hit, 6 invalid access, 7 FIFO overflow. An event pulse sets its bit on the next clock edge, and the bit stays set until it is cleared.
- R2: A write to the pending register (0x0C) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R3: Writing 1s to 0x10 clears those mask bits. Writing 1s to 0x14 sets those mask bits. Register 0x18 reads the mask in bits 7:0, and writes to it have no effect.
- R4: After reset the pending register reads 0, the mask reads 0xFF, `irq_o` is low and the done counter is 0.
- R5: `irq_o` is high exactly when some pending bit is set and its mask bit is clear. It follows every pending, unmask or mask-set write on the next cycle.
- R6: Each done event pulse adds one to the done counter, which is bits 15:13 of the status word. The counter wraps from 7 to 0.
- R7: A write of 1 to pending bit 1 while that bit is set subtracts one from the done counter, wrapping from 0 to 7. The same write while the bit is clear leaves the counter unchanged.
- R8: When an event pulse and a clearing write reach the same pending bit in the same cycle, the bit stays set.
- R9: Control (0x04) resets to 0x003FFA00 and stores all 32 bits written. Control-2 (0x08) resets to 0x0000FFF8 and stores only the bits in 0x07C0FFFF, with other bits reading 0.
- R10: The status word reads `busy_i` in bit 0 and the counter in bits 15:13, with all other bits 0. Writing 1s to bits 15:13 of 0x00 clears those counter bits.
- R11: Reads of 0x10 and 0x14 return 0. An access with a byte enable other than 4'hF, or with a nonzero address offset within the word, changes no state and reads 0.
- R12: A word access to an unmapped offset (0x1C) sets pending bit 6 and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| be_i | input | 4 | Byte enables; only 4'hF is accepted |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while a read is requested |
| busy_i | input | 1 | Channel busy flag from the datapath |
| evt_mem_done_i | input | 1 | Memory-side completion pulse |
| evt_done_i | input | 1 | Transfer completion pulse |
| evt_bus_err_i | input | 1 | Bus write-response error pulse |
| evt_strm_to_i | input | 1 | Stream timeout pulse |
| evt_mem_to_i | input | 1 | Memory timeout pulse |
| evt_thresh_i | input | 1 | FIFO threshold hit pulse |
| evt_ovfl_i | input | 1 | FIFO overflow pulse |
| irq_o | output | 1 | Level interrupt output |

## Verification
On every cycle, the assertions check these rules: event pulses set their pending bits, clearing writes clear only the bits written as 1, the unmask and mask-set writes move the mask in the right direction, and the mask holds its value otherwise. They also check the single-step and hold rules of the done counter, that the control words stay stable when not written, and that an unmapped access flags the invalid-access bit. Only the bench scenarios show the full-mask interrupt relation over every pending pattern, the counter wrap in both directions, and the outcome when an event and a clear collide. The bench scenarios also cover the ignored byte-enable and misaligned accesses, and the exact reset and read-back values of the control words.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NUM_SRC = 8;
  localparam int CNT_W   = 3;
  localparam int CNT_LSB = 13;

  // pending bit order, fixed by software decode
  localparam int SRC_MEM_DONE = 0;
  localparam int SRC_DONE     = 1;
  localparam int SRC_BUS_ERR  = 2;
  localparam int SRC_STRM_TO  = 3;
  localparam int SRC_MEM_TO   = 4;
  localparam int SRC_THRESH   = 5;
  localparam int SRC_BAD_ACC  = 6;
  localparam int SRC_OVFL     = 7;

  // word slots
  localparam int W_STATUS = 0;
  localparam int W_CTRL   = 1;
  localparam int W_CTRL2  = 2;
  localparam int W_PEND   = 3;
  localparam int W_UNMASK = 4;
  localparam int W_MASKSET = 5;
  localparam int W_MASK   = 6;

  localparam logic [31:0] CTRL_RST    = 32'h003F_FA00;
  localparam logic [31:0] CTRL_WMASK  = 32'hFFFF_FFFF;
  localparam logic [31:0] CTRL2_RST   = 32'h0000_FFF8;
  localparam logic [31:0] CTRL2_WMASK = 32'h07C0_FFFF;

  typedef struct packed {
    logic status;
    logic ctrl;
    logic ctrl2;
    logic pend;
    logic unmask;
    logic maskset;
  } wr_sel_t;
endpackage

// File: rtl/dma_irq_bus_dec.sv
module dma_irq_bus_dec
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  output wr_sel_t           wr_o,
  output logic              rd_en_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              bad_o
);
  logic word_ok, acc, mapped, wr_acc;

  assign word_ok = (&be_i) && (addr_i[1:0] == 2'b00);
  assign acc     = req_i && word_ok;
  assign idx_o   = addr_i[ADDR_W-1:2];
  assign mapped  = (idx_o <= IDX_W'(W_MASK));
  assign bad_o   = acc && !mapped;
  assign rd_en_o = acc && !we_i && mapped;
  assign wr_acc  = acc && we_i;

  always_comb begin
    wr_o         = '0;
    wr_o.status  = wr_acc && (idx_o == IDX_W'(W_STATUS));
    wr_o.ctrl    = wr_acc && (idx_o == IDX_W'(W_CTRL));
    wr_o.ctrl2   = wr_acc && (idx_o == IDX_W'(W_CTRL2));
    wr_o.pend    = wr_acc && (idx_o == IDX_W'(W_PEND));
    wr_o.unmask  = wr_acc && (idx_o == IDX_W'(W_UNMASK));
    wr_o.maskset = wr_acc && (idx_o == IDX_W'(W_MASKSET));
  end

  always_comb begin
    AST_ONE_WRITE: assert ($onehot0(wr_o)); // R11
  end
endmodule

// File: rtl/dma_irq_src_bank.sv
module dma_irq_src_bank
  import dma_irq_pkg::*;
#(
  parameter int NSRC     = NUM_SRC,
  parameter int DONE_BIT = SRC_DONE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            wr_pend_i,
  input  logic            wr_unmask_i,
  input  logic            wr_maskset_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o,
  output logic            done_ack_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic p_q, m_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        p_q <= 1'b0;
        m_q <= 1'b1;
      end else begin
        if (evt_i[k])                      p_q <= 1'b1; // event beats clear
        else if (wr_pend_i && wdata_i[k])  p_q <= 1'b0;
        if (wr_unmask_i && wdata_i[k])       m_q <= 1'b0;
        else if (wr_maskset_i && wdata_i[k]) m_q <= 1'b1;
      end
    end
    assign pend_o[k] = p_q;
    assign mask_o[k] = m_q;
  end

  assign irq_o      = |(pend_o & ~mask_o);
  assign done_ack_o = wr_pend_i && wdata_i[DONE_BIT] && pend_o[DONE_BIT];

  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((pend_o & $past(evt_i)) == $past(evt_i))); // R1
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pend_i && evt_i == '0) |=> (pend_o == ($past(pend_o) & ~$past(wdata_i)))); // R2
  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pend_i && |(evt_i & wdata_i)) |=> ((pend_o & $past(evt_i)) == $past(evt_i))); // R8
  AST_UNMASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_unmask_i |=> ((mask_o & $past(wdata_i)) == '0)); // R3
  AST_MASKSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_maskset_i |=> ((mask_o & $past(wdata_i)) == $past(wdata_i))); // R3
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_unmask_i && !wr_maskset_i) |=> $stable(mask_o)); // R3
endmodule

// File: rtl/dma_irq_done_cnt.sv
module dma_irq_done_cnt
  import dma_irq_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, base, nxt;

  always_comb begin
    base = clr_i ? (cnt_q & ~clr_bits_i) : cnt_q;
    nxt  = base + W'(inc_i) - W'(dec_i); // wraps mod 2**W
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;

  AST_CNT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && !clr_i) |=> (cnt_o == $past(cnt_o) + W'(1))); // R6
  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && !clr_i) |=> (cnt_o == $past(cnt_o) - W'(1))); // R7
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !dec_i && !clr_i) |=> $stable(cnt_o)); // R6
endmodule

// File: rtl/dma_irq_ctrl_store.sv
module dma_irq_ctrl_store #(
  parameter logic [31:0] RST_VAL = 32'h0,
  parameter logic [31:0] WMASK   = 32'hFFFF_FFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);
  logic [31:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_VAL & WMASK;
    else if (wr_i) q <= wdata_i & WMASK;
  end

  assign q_o = q;

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o)); // R9
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic              evt_mem_done_i,
  input  logic              evt_done_i,
  input  logic              evt_bus_err_i,
  input  logic              evt_strm_to_i,
  input  logic              evt_mem_to_i,
  input  logic              evt_thresh_i,
  input  logic              evt_ovfl_i,
  output logic              irq_o
);
  wr_sel_t             wr;
  logic                rd_en, bad, done_ack;
  logic [IDX_W-1:0]    idx;
  logic [NUM_SRC-1:0]  evt, pend, mask;
  logic [CNT_W-1:0]    cnt;
  logic [31:0]         ctrl_q, ctrl2_q, status_w, rdata;

  dma_irq_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .be_i(be_i),
    .wr_o(wr), .rd_en_o(rd_en), .idx_o(idx), .bad_o(bad)
  );

  always_comb begin
    evt               = '0;
    evt[SRC_MEM_DONE] = evt_mem_done_i;
    evt[SRC_DONE]     = evt_done_i;
    evt[SRC_BUS_ERR]  = evt_bus_err_i;
    evt[SRC_STRM_TO]  = evt_strm_to_i;
    evt[SRC_MEM_TO]   = evt_mem_to_i;
    evt[SRC_THRESH]   = evt_thresh_i;
    evt[SRC_BAD_ACC]  = bad;
    evt[SRC_OVFL]     = evt_ovfl_i;
  end

  dma_irq_src_bank #(.NSRC(NUM_SRC), .DONE_BIT(SRC_DONE)) u_src (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt),
    .wr_pend_i(wr.pend), .wr_unmask_i(wr.unmask), .wr_maskset_i(wr.maskset),
    .wdata_i(wdata_i[NUM_SRC-1:0]),
    .pend_o(pend), .mask_o(mask), .irq_o(irq_o), .done_ack_o(done_ack)
  );

  dma_irq_done_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(evt_done_i), .dec_i(done_ack),
    .clr_i(wr.status), .clr_bits_i(wdata_i[CNT_LSB+CNT_W-1:CNT_LSB]),
    .cnt_o(cnt)
  );

  dma_irq_ctrl_store #(.RST_VAL(CTRL_RST), .WMASK(CTRL_WMASK)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr.ctrl), .wdata_i(wdata_i), .q_o(ctrl_q)
  );

  dma_irq_ctrl_store #(.RST_VAL(CTRL2_RST), .WMASK(CTRL2_WMASK)) u_ctrl2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr.ctrl2), .wdata_i(wdata_i), .q_o(ctrl2_q)
  );

  always_comb begin
    status_w = '0;
    status_w[0] = busy_i;
    status_w[CNT_LSB +: CNT_W] = cnt;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (idx)
        IDX_W'(W_STATUS): rdata = status_w;
        IDX_W'(W_CTRL):   rdata = ctrl_q;
        IDX_W'(W_CTRL2):  rdata = ctrl2_q;
        IDX_W'(W_PEND):   rdata = 32'(pend);
        IDX_W'(W_MASK):   rdata = 32'(mask);
        default:          rdata = '0; // unmask / mask-set read zero
      endcase
    end
  end

  assign rdata_o = rdata;

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask) |-> !irq_o); // R5
  AST_BAD_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> pend[SRC_BAD_ACC]); // R12
endmodule

// File: tb/dma_irq_regs_tb.sv
module dma_irq_regs_tb_top;
  localparam logic [4:0] A_STATUS = 5'h00, A_CTRL = 5'h04, A_CTRL2 = 5'h08,
                         A_PEND = 5'h0C, A_UNMASK = 5'h10, A_MASKSET = 5'h14,
                         A_MASK = 5'h18, A_HOLE = 5'h1C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, busy = 1'b0;
  logic [4:0]  addr = '0;
  logic [3:0]  be = 4'hF;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  ev = '0;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_irq_regs #(.ADDR_W(5)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .busy_i(busy),
    .evt_mem_done_i(ev[0]), .evt_done_i(ev[1]), .evt_bus_err_i(ev[2]),
    .evt_strm_to_i(ev[3]), .evt_mem_to_i(ev[4]), .evt_thresh_i(ev[5]),
    .evt_ovfl_i(ev[7]), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk); req = 1'b0; we = 1'b0; be = 4'hF;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a; be = 4'hF;
    #5 d = rdata;
    @(posedge clk); #1 req = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk); ev = v; ev[6] = 1'b0;
    @(negedge clk); ev = '0;
  endtask

  task automatic set_mask(input logic [7:0] m);
    wr(A_MASKSET, 32'hFF, 4'hF);
    wr(A_UNMASK, 32'(~m), 4'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired before the end of the scenarios");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4 reset state
    rd(A_PEND, d);   chk("R4 pend", d, 32'h0);
    rd(A_MASK, d);   chk("R4 mask", d, 32'hFF);
    rd(A_STATUS, d); chk("R4 status", d, 32'h0);
    #1 chk("R4 irq", 32'(irq), 32'h0);

    // R9 control storage
    rd(A_CTRL, d);  chk("R9 ctrl reset", d, 32'h003F_FA00);
    rd(A_CTRL2, d); chk("R9 ctrl2 reset", d, 32'h0000_FFF8);
    wr(A_CTRL, 32'hA5C3_0F96, 4'hF);  rd(A_CTRL, d);  chk("R9 ctrl wr", d, 32'hA5C3_0F96);
    wr(A_CTRL2, 32'hFFFF_FFFF, 4'hF); rd(A_CTRL2, d); chk("R9 ctrl2 wr", d, 32'h07C0_FFFF);

    // R1 each event line to its bit; R2 clearing
    for (int b = 0; b < 8; b++) begin
      if (b == 6) continue;
      wr(A_PEND, 32'hFF, 4'hF);
      pulse(8'(1 << b));
      rd(A_PEND, d); chk($sformatf("R1 src %0d", b), d, 32'(1 << b));
    end
    wr(A_PEND, 32'hFF, 4'hF);
    pulse(8'hBF);
    wr(A_PEND, 32'h0000_0035, 4'hF);
    rd(A_PEND, d); chk("R2 partial clear", d, 32'h8A);
    wr(A_PEND, 32'h0, 4'hF);
    rd(A_PEND, d); chk("R2 zero write", d, 32'h8A);

    // R3 mask sweep
    for (int i = 0; i < 256; i++) begin
      set_mask(8'(i));
      rd(A_MASK, d); chk("R3 mask sweep", d, 32'(i));
    end
    set_mask(8'hF0);
    wr(A_MASK, 32'h0, 4'hF);
    rd(A_MASK, d); chk("R3 mask read only", d, 32'hF0);

    // R11 ignored accesses and zero reads
    wr(A_PEND, 32'hFF, 4'hF);
    wr(A_MASKSET, 32'h0F, 4'h1);
    wr(5'h15, 32'h0F, 4'hF);
    rd(A_MASK, d); chk("R11 partial/misaligned ignored", d, 32'hF0);
    rd(A_UNMASK, d);  chk("R11 unmask reads 0", d, 32'h0);
    rd(A_MASKSET, d); chk("R11 maskset reads 0", d, 32'h0);
    rd(A_PEND, d); chk("R11 no invalid flag", d, 32'h0);

    // R12 unmapped access
    rd(A_HOLE, d); chk("R12 hole reads 0", d, 32'h0);
    rd(A_PEND, d); chk("R12 invalid bit", d, 32'h40);

    // R1/R5 sweep of every pending pattern against nine masks
    for (int s = 0; s < 256; s++) begin
      wr(A_PEND, 32'hFF, 4'hF);
      pulse(8'(s));
      if (s[6]) rd(A_HOLE, d);
      rd(A_PEND, d); chk("R1 pattern", d, 32'(s));
      for (int j = 0; j < 9; j++) begin
        m = (j == 8) ? 8'hFF : ~(8'(1 << j));
        set_mask(m);
        #1 chk($sformatf("R5 irq s=%02h m=%02h", s, m), 32'(irq), 32'(|(8'(s) & ~m)));
      end
    end

    // R6/R7/R10 done counter
    busy = 1'b1;
    wr(A_PEND, 32'hFF, 4'hF);
    wr(A_STATUS, 32'h0000_E000, 4'hF);
    rd(A_STATUS, d); chk("R10 cleared, busy", d, 32'h1);
    for (int i = 0; i < 9; i++) pulse(8'h02);
    rd(A_STATUS, d); chk("R6 wrap to 1", d, 32'h2001);
    wr(A_PEND, 32'h02, 4'hF);
    rd(A_STATUS, d); chk("R7 ack decrements", d, 32'h0001);
    wr(A_PEND, 32'h02, 4'hF);
    rd(A_STATUS, d); chk("R7 ack while clear", d, 32'h0001);
    pulse(8'h02);
    wr(A_STATUS, 32'h0000_2000, 4'hF);
    rd(A_STATUS, d); chk("R10 counter bit clear", d, 32'h0001);
    wr(A_PEND, 32'h02, 4'hF);
    rd(A_STATUS, d); chk("R7 wrap to 7", d, 32'hE001);
    busy = 1'b0;

    // R8 event and clear in the same cycle
    pulse(8'h02);
    @(negedge clk);
    ev = 8'h82; req = 1'b1; we = 1'b1; addr = A_PEND; wdata = 32'h82;
    @(negedge clk);
    ev = '0; req = 1'b0; we = 1'b0;
    rd(A_PEND, d);   chk("R8 event wins", d, 32'h82);
    rd(A_STATUS, d); chk("R8 counter net zero", d, 32'h0000);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule